// File: doc/BRIEF.md
# Endpoint Configuration Header Register File

This block holds the configuration header of a single-function endpoint: identity and class codes, the command and status words, cache line size, latency timer, the interrupt routing bytes and six base address registers (BARs). Software reaches it through a simple register port. Each access carries a byte address, a byte count, a write enable and write data. Every accepted access gets a response exactly one cycle later, with read data and an error flag. The whole 256-byte space can be addressed. Only the first 64 bytes hold header fields, and the rest reads as zero. All header values come from parameters at reset.

Each BAR has a parameterised window size and can be marked as a fixed legacy I/O window. The BARs follow the standard sizing handshake. Writing all ones returns a size mask on the next read. Writing an address keeps the type bits in the low end of the register. For every BAR the block drives a decoded system address and a one-cycle pulse that tells a downstream address decoder the window has moved. The decoded address is the BAR address plus a parameterised I/O or memory window base.

The port control is a two-state machine. In ST_IDLE no response is pending. In ST_RESP a response is presented during the current cycle. Transitions: IDLE_TO_RESP and RESP_TO_RESP are taken when acc_valid is sampled high. RESP_TO_IDLE and IDLE_HOLD are taken when it is low.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, reads return the parameter values at their standard header offsets. Vendor is at 0x00, device at 0x02, command at 0x04, status at 0x06, revision/prog-if/subclass/class at 0x08..0x0B, cache line/latency/header type/self-test at 0x0C..0x0F, BARs at 0x10..0x24, interrupt line/pin/min-grant/max-latency at 0x3C..0x3F. The reserved words 0x34 and 0x38 read zero, and every byte at offset 0x40 or above reads zero. No BAR-changed pulse is present, non-legacy BAR decoded addresses are zero, and no response is valid.
- R2: Reads of 1, 2 or 4 bytes are allowed at any offset, including unaligned ones. The data is little-endian and right-aligned in rsp_rdata, and unused upper bits are zero. Writes return rsp_rdata = 0.
- R3: An access whose acc_size is not 1, 2 or 4 returns rsp_err = 1 and rsp_rdata = 0, and changes no state. All other accesses return rsp_err = 0.
- R4: A 1-byte write (data in acc_wdata[7:0]) changes state only at 0x0C (cache line size), 0x0D (latency timer) or 0x3C (interrupt line), and only that byte.
- R5: A 2-byte write (data in acc_wdata[15:0]) changes state only at 0x04 (command), 0x06 (status) or 0x0C. At 0x0C only the cache line size takes the low byte, and the latency timer is untouched.
- R6: Every other write is ignored. This covers identity bytes, the interrupt pin, 4-byte writes outside the BARs and unaligned BAR offsets.
- R7: A 4-byte write of 0xFFFFFFFF to a non-legacy BAR stores ~(SIZE-1) in the address bits and keeps the type bits. A size of 0 therefore reads back only the type bits. Each size must be 0 or a power of two, and any other value stops elaboration.
- R8: Any other 4-byte BAR write stores (new & ~m) | (old & m). Here m = 0x3 when the old bit 0 is 1 (I/O BAR), and m = 0xF otherwise (memory BAR).
- R9: When (new & ~m) is nonzero, the BAR's decoded address becomes window base + (new & ~m) in the cycle after the write. The I/O base is used for I/O BARs and the memory base for memory BARs. bar_changed for that BAR is high for exactly that one cycle. A sizing write, or a write whose address bits are zero, leaves the decoded address alone and raises no pulse.
- R10: A legacy BAR always reads zero and ignores writes. It never pulses, and its decoded address is fixed at I/O window base + its reset value.
- R11: rsp_valid is high in the cycle after each cycle with acc_valid high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset into configuration space |
| acc_size | input | 3 | Byte count (1, 2 or 4 legal) |
| acc_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Right-aligned read data |
| rsp_err | output | 1 | Illegal byte count |
| bar_base | output | 192 | Decoded address per BAR, BAR i in bits [32i+31:32i] |
| bar_changed | output | 6 | One-cycle pulse per BAR when its decoded address moves |

## Verification
The hardest situations to reach from the ports are the BAR writes that must not move the decoded window. These are a sizing write, a write whose only nonzero bits fall inside the type mask, a write to a zero-size BAR and any write to a legacy BAR. Each of them looks like an ordinary BAR store at the register port. The stimulus therefore pairs every such write with a read-back of the BAR and a direct look at bar_base and bar_changed in the cycle after. It does this on both a memory and an I/O BAR, so the two type masks are exercised on the same path.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int NUM_BARS   = 6;
    localparam int DW         = 32;
    localparam int HDR_DWORDS = 16;
    localparam int HDR_BYTES  = HDR_DWORDS * 4;

    localparam logic [7:0] OFF_CMD      = 8'h04;
    localparam logic [7:0] OFF_STATUS   = 8'h06;
    localparam logic [7:0] OFF_CLS      = 8'h0C;
    localparam logic [7:0] OFF_LAT      = 8'h0D;
    localparam logic [7:0] OFF_INTLINE  = 8'h3C;
    localparam logic [7:0] OFF_BAR_LO   = 8'h10;
    localparam logic [7:0] OFF_BAR_HI   = 8'h24;

    localparam logic [DW-1:0] IO_TYPE_MASK  = 32'h0000_0003;
    localparam logic [DW-1:0] MEM_TYPE_MASK = 32'h0000_000F;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_state_e;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter logic [DW-1:0] INIT      = '0,
    parameter logic [DW-1:0] SIZE      = '0,
    parameter bit            LEGACY    = 1'b0,
    parameter logic [DW-1:0] IO_BASE   = '0,
    parameter logic [DW-1:0] MEM_BASE  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] base,
    output logic          changed
);

    localparam logic [DW-1:0] ALL_ONES  = '1;
    localparam logic [DW-1:0] SIZE_MASK = ~(SIZE - 1'b1);

    if (LEGACY) begin : g_legacy
        logic unused_legacy_in;
        assign unused_legacy_in = ^{clk, rst_n, wr_en, wdata};
        assign rd_val  = '0;
        assign base    = IO_BASE + INIT;
        assign changed = 1'b0;
    end else begin : g_live
        if ((SIZE != '0) && ((SIZE & (SIZE - 1'b1)) != '0)) begin : g_bad_size
            $error("BAR window size must be zero or a power of two");
        end

        logic [DW-1:0] bar_q;
        logic [DW-1:0] base_q;
        logic          changed_q;
        logic [DW-1:0] keep_mask;
        logic          sizing;
        logic [DW-1:0] addr_part;
        logic [DW-1:0] bar_d;
        logic          moves;

        always_comb begin
            keep_mask = bar_q[0] ? IO_TYPE_MASK : MEM_TYPE_MASK;
            sizing    = (wdata == ALL_ONES);
            addr_part = wdata & ~keep_mask;
            if (sizing) begin
                bar_d = (SIZE_MASK & ~keep_mask) | (bar_q & keep_mask);
            end else begin
                bar_d = addr_part | (bar_q & keep_mask);
            end
            moves = wr_en && !sizing && (addr_part != '0);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bar_q     <= INIT;
                base_q    <= '0;
                changed_q <= 1'b0;
            end else begin
                changed_q <= moves;
                if (wr_en) begin
                    bar_q <= bar_d;
                end
                if (moves) begin
                    base_q <= (bar_q[0] ? IO_BASE : MEM_BASE) + addr_part;
                end
            end
        end

        assign rd_val  = bar_q;
        assign base    = base_q;
        assign changed = changed_q;
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_hdr_pkg::*;
(
    input  logic [HDR_BYTES*8-1:0] hdr_bytes,
    input  logic [7:0]             addr,
    input  logic [2:0]             size,
    output logic [DW-1:0]          rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < 4; i++) begin
            int bi;
            bi = int'(addr) + i;
            if ((i < int'(size)) && (bi < HDR_BYTES)) begin
                rdata[i*8 +: 8] = hdr_bytes[bi*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'hABCD,
    parameter logic [15:0] DEVICE_ID     = 16'h1234,
    parameter logic [15:0] CMD_INIT      = 16'h0000,
    parameter logic [15:0] STATUS_INIT   = 16'h0010,
    parameter logic [7:0]  REV_ID        = 8'h01,
    parameter logic [7:0]  PROG_IF       = 8'h00,
    parameter logic [7:0]  SUBCLASS      = 8'h00,
    parameter logic [7:0]  CLASS_CODE    = 8'h02,
    parameter logic [7:0]  CLS_INIT      = 8'h00,
    parameter logic [7:0]  LAT_INIT      = 8'h00,
    parameter logic [7:0]  HDR_TYPE      = 8'h00,
    parameter logic [7:0]  BIST_INIT     = 8'h00,
    parameter logic [NUM_BARS*DW-1:0] BAR_INIT = {
        32'h0000_0000, 32'h0000_0000, 32'h0000_03F8,
        32'h0000_0000, 32'h0000_0001, 32'h0000_0008},
    parameter logic [NUM_BARS*DW-1:0] BAR_SIZE = {
        32'h0000_0000, 32'h0010_0000, 32'h0000_0008,
        32'h0000_0000, 32'h0000_0100, 32'h0000_1000},
    parameter logic [NUM_BARS-1:0] BAR_LEGACY = 6'b001000,
    parameter logic [31:0] CIS_PTR       = 32'h0000_0000,
    parameter logic [15:0] SUBSYS_VENDOR = 16'h5A5A,
    parameter logic [15:0] SUBSYS_ID     = 16'h0042,
    parameter logic [31:0] ROM_BASE      = 32'h0000_0000,
    parameter logic [7:0]  INTLINE_INIT  = 8'h0A,
    parameter logic [7:0]  INTPIN        = 8'h01,
    parameter logic [7:0]  MIN_GNT       = 8'h00,
    parameter logic [7:0]  MAX_LAT       = 8'h00,
    parameter logic [31:0] IO_WINDOW_BASE  = 32'hC000_0000,
    parameter logic [31:0] MEM_WINDOW_BASE = 32'h4000_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_we,
    input  logic [7:0]             acc_addr,
    input  logic [2:0]             acc_size,
    input  logic [31:0]            acc_wdata,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_rdata,
    output logic                   rsp_err,
    output logic [NUM_BARS*DW-1:0] bar_base,
    output logic [NUM_BARS-1:0]    bar_changed
);

    // ---------------- port state machine ----------------
    port_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = acc_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = acc_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- access decode ----------------
    logic       legal;
    logic       wr_any;
    logic       wr_b1, wr_b2, wr_b4;
    logic       bar_hit;
    logic [2:0] bar_idx;

    always_comb begin
        legal   = size_legal(acc_size);
        wr_any  = acc_valid && acc_we && legal;
        wr_b1   = wr_any && (acc_size == 3'd1);
        wr_b2   = wr_any && (acc_size == 3'd2);
        wr_b4   = wr_any && (acc_size == 3'd4);
        bar_hit = wr_b4 && (acc_addr >= OFF_BAR_LO) && (acc_addr <= OFF_BAR_HI)
                  && (acc_addr[1:0] == 2'b00);
        bar_idx = 3'((acc_addr - OFF_BAR_LO) >> 2);
    end

    // ---------------- writable header fields ----------------
    logic [15:0] cmd_q;
    logic [15:0] status_q;
    logic [7:0]  cls_q;
    logic [7:0]  lat_q;
    logic [7:0]  intline_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_INIT;
            status_q  <= STATUS_INIT;
            cls_q     <= CLS_INIT;
            lat_q     <= LAT_INIT;
            intline_q <= INTLINE_INIT;
        end else begin
            if (wr_b1) begin
                unique case (acc_addr)
                    OFF_CLS:     cls_q     <= acc_wdata[7:0];
                    OFF_LAT:     lat_q     <= acc_wdata[7:0];
                    OFF_INTLINE: intline_q <= acc_wdata[7:0];
                    default: ;
                endcase
            end
            if (wr_b2) begin
                unique case (acc_addr)
                    OFF_CMD:    cmd_q    <= acc_wdata[15:0];
                    OFF_STATUS: status_q <= acc_wdata[15:0];
                    OFF_CLS:    cls_q    <= acc_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    // ---------------- base address registers ----------------
    logic [DW-1:0] bar_rd [NUM_BARS];

    for (genvar gi = 0; gi < NUM_BARS; gi++) begin : g_bar
        logic slot_we;
        assign slot_we = bar_hit && (bar_idx == 3'(gi));

        cfg_bar_slot #(
            .INIT     (BAR_INIT[gi*DW +: DW]),
            .SIZE     (BAR_SIZE[gi*DW +: DW]),
            .LEGACY   (BAR_LEGACY[gi]),
            .IO_BASE  (IO_WINDOW_BASE),
            .MEM_BASE (MEM_WINDOW_BASE)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (slot_we),
            .wdata   (acc_wdata),
            .rd_val  (bar_rd[gi]),
            .base    (bar_base[gi*DW +: DW]),
            .changed (bar_changed[gi])
        );
    end

    // ---------------- header image and read path ----------------
    logic [DW-1:0]          hdr_dw [HDR_DWORDS];
    logic [HDR_BYTES*8-1:0] hdr_bytes;

    always_comb begin
        hdr_dw[0]  = {DEVICE_ID, VENDOR_ID};
        hdr_dw[1]  = {status_q, cmd_q};
        hdr_dw[2]  = {CLASS_CODE, SUBCLASS, PROG_IF, REV_ID};
        hdr_dw[3]  = {BIST_INIT, HDR_TYPE, lat_q, cls_q};
        for (int b = 0; b < NUM_BARS; b++) begin
            hdr_dw[4 + b] = bar_rd[b];
        end
        hdr_dw[10] = CIS_PTR;
        hdr_dw[11] = {SUBSYS_ID, SUBSYS_VENDOR};
        hdr_dw[12] = ROM_BASE;
        hdr_dw[13] = '0;
        hdr_dw[14] = '0;
        hdr_dw[15] = {MAX_LAT, MIN_GNT, INTPIN, intline_q};
        for (int k = 0; k < HDR_DWORDS; k++) begin
            hdr_bytes[k*DW +: DW] = hdr_dw[k];
        end
    end

    logic [DW-1:0] rd_word;

    cfg_read_mux u_rmux (
        .hdr_bytes (hdr_bytes),
        .addr      (acc_addr),
        .size      (acc_size),
        .rdata     (rd_word)
    );

    // ---------------- response outputs ----------------
    logic [DW-1:0] rdata_q;
    logic          err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (acc_valid) begin
            err_q   <= !legal;
            rdata_q <= (legal && !acc_we) ? rd_word : '0;
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rdata_q;
        rsp_err   = err_q;
    end

endmodule

// File: rtl/cfg_header_regs_chk.sv
module cfg_header_regs_chk
    import cfg_hdr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_valid,
    input logic                   acc_we,
    input logic [2:0]             acc_size,
    input logic                   rsp_valid,
    input logic                   rsp_err,
    input logic [NUM_BARS*DW-1:0] bar_base,
    input logic [NUM_BARS-1:0]    bar_changed
);

    // R11
    rsp_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    // R3
    err_needs_bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !size_legal($past(acc_size)));

    // R9
    changed_needs_wide_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_changed != '0) |-> $past(acc_valid && acc_we && (acc_size == 3'd4)));

    // R9
    changed_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bar_changed));

    for (genvar gi = 0; gi < NUM_BARS; gi++) begin : g_bar_chk
        // R9 R10
        base_moves_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bar_changed[gi] |-> $stable(bar_base[gi*DW +: DW]));
    end

endmodule

bind cfg_header_regs cfg_header_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_we      (acc_we),
    .acc_size    (acc_size),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .bar_base    (bar_base),
    .bar_changed (bar_changed)
);

// File: tb/cfg_header_regs_tb.sv
module cfg_header_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0;
    logic         acc_we = 1'b0;
    logic [7:0]   acc_addr = '0;
    logic [2:0]   acc_size = '0;
    logic [31:0]  acc_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         rsp_err;
    logic [191:0] bar_base;
    logic [5:0]   bar_changed;

    int n_checks = 0;
    int n_fails  = 0;

    logic [32:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_header_regs dut_i (
        .clk (clk), .rst_n (rst_n),
        .acc_valid (acc_valid), .acc_we (acc_we), .acc_addr (acc_addr),
        .acc_size (acc_size), .acc_wdata (acc_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_err (rsp_err),
        .bar_base (bar_base), .bar_changed (bar_changed)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: push expected response, then present the access for one cycle.
    task automatic access(input logic we, input logic [7:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp_rd,
                          input logic exp_err, input string tag);
        exp_q.push_back({exp_err, exp_rd});
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_we = we; acc_addr = a; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [2:0] sz,
                      input logic [31:0] exp, input string tag);
        access(1'b0, a, sz, '0, exp, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] sz,
                      input logic [31:0] d, input string tag);
        access(1'b1, a, sz, d, 32'h0, 1'b0, tag);
    endtask

    // Monitor: compare each response against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL R11: got unexpected response %h expected none", rsp_rdata);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " data"}, rsp_rdata, e[31:0]);
                    chk({t, " err"}, {31'b0, rsp_err}, {31'b0, e[32]});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : stimulus
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R1 bar_changed", {26'b0, bar_changed}, 32'h0);
        chk("R1 base0", bar_base[0*32 +: 32], 32'h0);
        chk("R10 base3 reset", bar_base[3*32 +: 32], 32'hC000_03F8);

        rd(8'h00, 3'd4, 32'h1234_ABCD, "R1 id");
        rd(8'h08, 3'd4, 32'h0200_0001, "R1 class");
        rd(8'h3C, 3'd4, 32'h0000_010A, "R1 int");
        rd(8'h10, 3'd4, 32'h0000_0008, "R1 bar0");
        rd(8'h14, 3'd4, 32'h0000_0001, "R1 bar1");
        rd(8'h2C, 3'd4, 32'h0042_5A5A, "R1 subsys");
        rd(8'h34, 3'd4, 32'h0, "R1 reserved34");
        rd(8'h38, 3'd4, 32'h0, "R1 reserved38");
        rd(8'h80, 3'd4, 32'h0, "R1 beyond");
        rd(8'h06, 3'd2, 32'h0000_0010, "R1 status");

        // R2: sizes and unaligned reads
        rd(8'h01, 3'd1, 32'h0000_00AB, "R2 byte");
        rd(8'h01, 3'd2, 32'h0000_34AB, "R2 unaligned half");
        rd(8'h3E, 3'd4, 32'h0, "R2 straddle end");
        rd(8'h3D, 3'd4, 32'h0000_0001, "R2 tail bytes");

        // R4: byte writes
        wr(8'h3C, 3'd1, 32'hFFFF_FF55, "R4 intline wr");
        rd(8'h3C, 3'd4, 32'h0000_0155, "R4 intline");
        wr(8'h0C, 3'd1, 32'h0000_0010, "R4 cls wr");
        wr(8'h0D, 3'd1, 32'h0000_0040, "R4 lat wr");
        rd(8'h0C, 3'd2, 32'h0000_4010, "R4 cls lat");
        wr(8'h3D, 3'd1, 32'h0000_0077, "R6 intpin wr");
        rd(8'h3D, 3'd1, 32'h0000_0001, "R6 intpin kept");

        // R5: half writes
        wr(8'h04, 3'd2, 32'hFFFF_0007, "R5 cmd wr");
        rd(8'h04, 3'd2, 32'h0000_0007, "R5 cmd");
        wr(8'h06, 3'd2, 32'h0000_0000, "R5 status wr");
        rd(8'h06, 3'd2, 32'h0000_0000, "R5 status");
        wr(8'h0C, 3'd2, 32'h0000_BEEF, "R5 cls half wr");
        rd(8'h0C, 3'd2, 32'h0000_40EF, "R5 cls half");
        rd(8'h02, 3'd4, 32'h0007_1234, "R2 unaligned word");

        // R6: ignored writes
        wr(8'h00, 3'd2, 32'h0000_1111, "R6 vendor wr");
        rd(8'h00, 3'd2, 32'h0000_ABCD, "R6 vendor kept");
        wr(8'h04, 3'd4, 32'h0000_FFFF, "R6 cmd word wr");
        rd(8'h04, 3'd2, 32'h0000_0007, "R6 cmd kept");
        wr(8'h12, 3'd4, 32'h0000_7000, "R6 bar unaligned wr");
        rd(8'h10, 3'd4, 32'h0000_0008, "R6 bar0 kept");

        // R3: illegal size
        access(1'b0, 8'h00, 3'd3, 32'h0, 32'h0, 1'b1, "R3 read size3");
        access(1'b1, 8'h3C, 3'd3, 32'h99, 32'h0, 1'b1, "R3 write size3");
        rd(8'h3C, 3'd1, 32'h0000_0055, "R3 intline kept");

        // R7: sizing handshake
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, "R7 bar0 size wr");
        chk("R9 no pulse on sizing", {26'b0, bar_changed}, 32'h0);
        rd(8'h10, 3'd4, 32'hFFFF_F008, "R7 bar0 mask");
        wr(8'h14, 3'd4, 32'hFFFF_FFFF, "R7 bar1 size wr");
        rd(8'h14, 3'd4, 32'hFFFF_FF01, "R7 bar1 mask");
        wr(8'h18, 3'd4, 32'hFFFF_FFFF, "R7 bar2 size wr");
        rd(8'h18, 3'd4, 32'h0, "R7 bar2 zero size");

        // R8 / R9: address writes
        wr(8'h10, 3'd4, 32'h1234_5005, "R8 bar0 wr");
        chk("R9 bar0 pulse", {26'b0, bar_changed}, 32'h0000_0001);
        chk("R9 bar0 base", bar_base[0*32 +: 32], 32'h5234_5000);
        @(negedge clk);
        chk("R9 pulse one cycle", {26'b0, bar_changed}, 32'h0);
        rd(8'h10, 3'd4, 32'h1234_5008, "R8 bar0 value");
        wr(8'h14, 3'd4, 32'h0000_E003, "R8 bar1 wr");
        chk("R9 bar1 pulse", {26'b0, bar_changed}, 32'h0000_0002);
        chk("R9 bar1 base", bar_base[1*32 +: 32], 32'hC000_E000);
        rd(8'h14, 3'd4, 32'h0000_E001, "R8 bar1 value");
        wr(8'h20, 3'd4, 32'h0000_000F, "R9 bar4 low wr");
        chk("R9 bar4 no pulse", {26'b0, bar_changed}, 32'h0);
        chk("R9 bar4 base kept", bar_base[4*32 +: 32], 32'h0);
        rd(8'h20, 3'd4, 32'h0, "R8 bar4 value");

        // R10: legacy BAR
        wr(8'h1C, 3'd4, 32'h1234_0000, "R10 bar3 wr");
        chk("R10 bar3 no pulse", {26'b0, bar_changed}, 32'h0);
        chk("R10 bar3 base", bar_base[3*32 +: 32], 32'hC000_03F8);
        rd(8'h1C, 3'd4, 32'h0, "R10 bar3 reads zero");

        repeat (3) @(negedge clk);
        chk("R11 queue drained", exp_q.size(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule